// File: doc/BRIEF.md
# Saturating Threshold Multiplicity Merger

This block collects hit reports from a set of upstream cluster-finding sources. Each source can flag two candidate objects, one for its left half and one for its right half. For every object it supplies one pass bit per energy threshold. Once per bunch crossing the block counts, for each threshold, how many of the object slots passed it. Each count is emitted as a small saturating number, so a downstream trigger stage sees one multiplicity per threshold.

Each source drives a 16-line link at twice the bunch-crossing rate, so a frame is two beats. The first beat carries the pass masks. The second beat carries a valid flag for each half and an even-parity bit. The block checks parity on every link. A link that fails sets a sticky error flag, which stays set until a synchronous clear. Data on a failing link is still counted.

Top module: `thr_mult_merger`

## Requirements
- R1: While `rst` is high, and after it is released until the first frame completes, `cnt_out`, `cnt_valid` and `err_flags` are all zero.
- R2: Threshold t's count sits at `cnt_out[3t+2:3t]`. It equals the number of valid object slots whose pass bit t is set. For source s, first-beat bits [7:0] of `src_lines[16s+15:16s]` are the left-object pass bits and bits [15:8] are the right-object pass bits.
- R3: A count never wraps. When more than 7 slots pass a threshold, its field reads 7. Exactly 7 passing slots also reads 7.
- R4: Second-beat bit 0 is the left-object valid flag and bit 1 is the right-object valid flag. A slot whose flag is 0 adds nothing to any count, whatever its pass bits hold.
- R5: A frame starts in a cycle with `beat_first` high, and the next cycle carries the second beat. `beat_first` is not honoured in a cycle that carries a second beat. The new counts appear on the second rising edge after the edge that samples the second beat. `cnt_valid` is high for exactly that one cycle.
- R6: Between frames, `cnt_out` holds its last value.
- R7: Second-beat bit 2 is an even-parity bit covering first-beat bits [15:0] and second-beat bits [1:0]. A mismatch on source s sets `err_flags[s]` by the time the counts of that frame appear.
- R8: An error flag is sticky. It stays set over later good frames. The failing source's slots are still counted.
- R9: `err_clear` high at a rising edge clears all error flags at that edge. It takes priority over a parity error arriving at the same edge.
- R10: Second-beat bits [15:3] are ignored. They affect neither the counts nor the error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bunch-crossing rate |
| rst | input | 1 | Synchronous active-high reset |
| beat_first | input | 1 | Marks the first beat of a frame |
| src_lines | input | NSRC*2*NTHR (128) | Link lines of all sources, source s at [16s+15:16s] |
| err_clear | input | 1 | Synchronous clear of all error flags |
| cnt_out | output | NTHR*CNT_W (24) | Saturating count per threshold |
| cnt_valid | output | 1 | One-cycle pulse when new counts appear |
| err_flags | output | NSRC (8) | Sticky parity error flag per source |

## Verification
The bench builds the block with its defaults: eight sources, eight thresholds and three-bit counts. With these values all sixteen slots can pass one threshold together. That allows a count of exactly seven (seven slots) and a saturated count from sixteen slots. Every slot that is marked invalid carries all-ones pass bits, so a gating fault shows up as an inflated count. Parity is corrupted on single links and on a pair of links, which shows that each error flag is independent, sticky, and cleared together with the others.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
  // second-beat field positions
  localparam int unsigned VL_BIT  = 0;
  localparam int unsigned VR_BIT  = 1;
  localparam int unsigned PAR_BIT = 2;

  typedef enum logic {
    PH_B0 = 1'b0,
    PH_B1 = 1'b1
  } beat_ph_e;
endpackage

// File: rtl/mrg_framer.sv
module mrg_framer
  import mrg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic beat_first,
  output logic take_b0,
  output logic take_b1,
  output logic s1_valid
);
  beat_ph_e ph_q;

  assign take_b0 = beat_first && (ph_q == PH_B0);
  assign take_b1 = (ph_q == PH_B1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PH_B0;
      s1_valid <= 1'b0;
    end else begin
      ph_q     <= take_b0 ? PH_B1 : PH_B0;
      s1_valid <= take_b1;
    end
  end
endmodule

// File: rtl/mrg_link_rx.sv
module mrg_link_rx
  import mrg_pkg::*;
#(
  parameter int unsigned NTHR = 8,
  localparam int unsigned LINE_W = 2 * NTHR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_b0,
  input  logic              take_b1,
  input  logic [LINE_W-1:0] lines,
  output logic [NTHR-1:0]   hit_l,
  output logic [NTHR-1:0]   hit_r,
  output logic              perr
);
  logic [LINE_W-1:0] beat0_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat0_q <= '0;
      hit_l   <= '0;
      hit_r   <= '0;
      perr    <= 1'b0;
    end else begin
      if (take_b0) beat0_q <= lines;
      if (take_b1) begin
        hit_l <= beat0_q[NTHR-1:0]      & {NTHR{lines[VL_BIT]}};
        hit_r <= beat0_q[LINE_W-1:NTHR] & {NTHR{lines[VR_BIT]}};
        perr  <= ^{beat0_q, lines[PAR_BIT:0]};
      end
    end
  end
endmodule

// File: rtl/mrg_thr_count.sv
module mrg_thr_count #(
  parameter int unsigned NSLOT = 16,
  parameter int unsigned CNT_W = 3,
  localparam int unsigned RAW_W = $clog2(NSLOT + 1),
  localparam int unsigned MAXC  = (1 << CNT_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_raw,
  input  logic             load_out,
  input  logic [NSLOT-1:0] slots,
  output logic [CNT_W-1:0] cnt
);
  logic [RAW_W-1:0] raw_d, raw_q;

  always_comb begin
    raw_d = '0;
    for (int i = 0; i < NSLOT; i++) raw_d = raw_d + RAW_W'(slots[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
      cnt   <= '0;
    end else begin
      if (load_raw) raw_q <= raw_d;
      if (load_out) begin
        if (int'(raw_q) > int'(MAXC)) cnt <= CNT_W'(MAXC);
        else                          cnt <= CNT_W'(raw_q);
      end
    end
  end
endmodule

// File: rtl/thr_mult_merger.sv
module thr_mult_merger #(
  parameter int unsigned NSRC  = 8,
  parameter int unsigned NTHR  = 8,
  parameter int unsigned CNT_W = 3,
  localparam int unsigned LINE_W = 2 * NTHR,
  localparam int unsigned NSLOT  = 2 * NSRC
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   beat_first,
  input  logic [NSRC*LINE_W-1:0] src_lines,
  input  logic                   err_clear,
  output logic [NTHR*CNT_W-1:0]  cnt_out,
  output logic                   cnt_valid,
  output logic [NSRC-1:0]        err_flags
);
  logic take_b0, take_b1, s1_valid, s2_valid;
  logic [NTHR-1:0] hit_l [NSRC];
  logic [NTHR-1:0] hit_r [NSRC];
  logic [NSRC-1:0] perr;

  mrg_framer u_framer (
    .clk(clk), .rst(rst), .beat_first(beat_first),
    .take_b0(take_b0), .take_b1(take_b1), .s1_valid(s1_valid)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_link
    mrg_link_rx #(.NTHR(NTHR)) u_link (
      .clk(clk), .rst(rst), .take_b0(take_b0), .take_b1(take_b1),
      .lines(src_lines[s*LINE_W +: LINE_W]),
      .hit_l(hit_l[s]), .hit_r(hit_r[s]), .perr(perr[s])
    );
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [NSLOT-1:0] slots;
    for (genvar s = 0; s < NSRC; s++) begin : g_slot
      assign slots[2*s]   = hit_l[s][t];
      assign slots[2*s+1] = hit_r[s][t];
    end
    mrg_thr_count #(.NSLOT(NSLOT), .CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .load_raw(s1_valid), .load_out(s2_valid),
      .slots(slots), .cnt(cnt_out[t*CNT_W +: CNT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid  <= 1'b0;
      cnt_valid <= 1'b0;
      err_flags <= '0;
    end else begin
      s2_valid  <= s1_valid;
      cnt_valid <= s2_valid;
      if (err_clear)     err_flags <= '0;
      else if (s1_valid) err_flags <= err_flags | perr;
    end
  end
endmodule

// File: rtl/mrg_checker.sv
module mrg_checker #(
  parameter int unsigned NSRC  = 8,
  parameter int unsigned NTHR  = 8,
  parameter int unsigned CNT_W = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  beat_first,
  input logic                  err_clear,
  input logic [NTHR*CNT_W-1:0] cnt_out,
  input logic                  cnt_valid,
  input logic [NSRC-1:0]       err_flags
);
  assert_upd_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_valid |=> !cnt_valid);

  assert_frame_latency_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_valid |-> $past(beat_first, 4));

  assert_hold_between_R6: assert property (@(posedge clk) disable iff (rst)
    !cnt_valid |-> $stable(cnt_out));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(err_clear) |-> ((err_flags & $past(err_flags)) == $past(err_flags)));

  assert_err_clear_R9: assert property (@(posedge clk) disable iff (rst)
    err_clear |=> (err_flags == '0));
endmodule

bind thr_mult_merger mrg_checker #(.NSRC(NSRC), .NTHR(NTHR), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .beat_first(beat_first), .err_clear(err_clear),
  .cnt_out(cnt_out), .cnt_valid(cnt_valid), .err_flags(err_flags)
);

// File: tb/sim_thr_mult_merger.sv
`timescale 1ns/1ps
module sim_thr_mult_merger;
  localparam int NSRC = 8, NTHR = 8, CNT_W = 3;
  localparam int LINE_W = 2 * NTHR;
  localparam int BUS_W = NSRC * LINE_W;

  logic clk = 1'b0, rst = 1'b1, beat_first = 1'b0, err_clear = 1'b0;
  logic [BUS_W-1:0] src_lines = '0;
  logic [NTHR*CNT_W-1:0] cnt_out;
  logic cnt_valid;
  logic [NSRC-1:0] err_flags;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  thr_mult_merger #(.NSRC(NSRC), .NTHR(NTHR), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .beat_first(beat_first), .src_lines(src_lines),
    .err_clear(err_clear), .cnt_out(cnt_out), .cnt_valid(cnt_valid),
    .err_flags(err_flags)
  );

  // {left-valid count, right-valid count, left mask, right mask, expected counts}
  localparam logic [47:0] VEC [8] = '{
    {4'd0, 4'd0, 8'hFF, 8'hFF, 24'h000000},
    {4'd1, 4'd0, 8'h01, 8'hFF, 24'h000001},
    {4'd3, 4'd2, 8'h0F, 8'h03, 24'h0006ED},
    {4'd8, 4'd8, 8'hFF, 8'hFF, 24'hFFFFFF},
    {4'd4, 4'd3, 8'h80, 8'h80, 24'hE00000},
    {4'd4, 4'd4, 8'h80, 8'h00, 24'h800000},
    {4'd8, 4'd0, 8'h55, 8'h00, 24'h1C71C7},
    {4'd2, 4'd5, 8'hA0, 8'h20, 24'h438000}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Sources below nl (nr) have the left (right) object valid; invalid slots carry all-ones masks.
  task automatic mk(input int nl, input int nr, input logic [7:0] ml, input logic [7:0] mr,
                    input logic [NSRC-1:0] bad, input logic resv,
                    output logic [BUS_W-1:0] w0, output logic [BUS_W-1:0] w1);
    for (int s = 0; s < NSRC; s++) begin
      logic vl, vr, par;
      logic [15:0] b0w;
      vl  = (s < nl);
      vr  = (s < nr);
      b0w = {vr ? mr : 8'hFF, vl ? ml : 8'hFF};
      par = ^{b0w, vr, vl};
      if (bad[s]) par = ~par;
      w0[s*LINE_W +: LINE_W] = b0w;
      w1[s*LINE_W +: LINE_W] = {resv ? 13'h1FFF : 13'h0000, par, vr, vl};
    end
  endtask

  task automatic send(input logic [BUS_W-1:0] w0, input logic [BUS_W-1:0] w1);
    beat_first = 1'b1; src_lines = w0;
    @(negedge clk);
    beat_first = 1'b0; src_lines = w1;
    @(negedge clk);
    src_lines = '0;
  endtask

  task automatic wait_res();
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5.0);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [BUS_W-1:0] w0, w1;
    repeat (4) @(negedge clk);
    check(32'(cnt_out), 0, "R1 counts in reset");
    check(32'(cnt_valid), 0, "R1 valid in reset");
    rst = 1'b0;
    @(negedge clk);
    check(32'(err_flags), 0, "R1 flags after reset");

    for (int i = 0; i < 8; i++) begin
      mk(int'(VEC[i][47:44]), int'(VEC[i][43:40]), VEC[i][39:32], VEC[i][31:24],
         '0, i[0], w0, w1);
      send(w0, w1);
      wait_res();
      check(32'(cnt_out), 32'(VEC[i][23:0]), $sformatf("R2 R3 R4 R10 vector %0d", i));
      check(32'(cnt_valid), 1, "R5 valid pulse present");
      check(32'(err_flags), 0, "R7 R10 no error on good parity");
    end

    // latency and pulse width
    mk(8, 8, 8'hFF, 8'hFF, '0, 1'b0, w0, w1);
    send(w0, w1);
    @(negedge clk);
    check(32'(cnt_out), 32'h438000, "R5 counts not yet updated");
    check(32'(cnt_valid), 0, "R5 valid not yet high");
    @(negedge clk);
    check(32'(cnt_out), 32'hFFFFFF, "R5 R3 counts updated");
    @(negedge clk);
    check(32'(cnt_valid), 0, "R5 valid one cycle only");
    repeat (5) @(negedge clk);
    check(32'(cnt_out), 32'hFFFFFF, "R6 hold between frames");

    // parity error on source 3, still counted
    mk(4, 0, 8'h01, 8'h00, 8'h08, 1'b0, w0, w1);
    send(w0, w1);
    wait_res();
    check(32'(err_flags), 32'h08, "R7 parity error flag");
    check(32'(cnt_out), 32'h000004, "R8 failing source still counted");

    mk(0, 0, 8'h00, 8'h00, '0, 1'b1, w0, w1);
    send(w0, w1);
    wait_res();
    check(32'(err_flags), 32'h08, "R8 flag sticky over good frame");
    check(32'(cnt_out), 0, "R4 all slots invalid");

    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    check(32'(err_flags), 0, "R9 clear");

    mk(1, 1, 8'h02, 8'h02, 8'h81, 1'b1, w0, w1);
    send(w0, w1);
    wait_res();
    check(32'(err_flags), 32'h81, "R7 independent flags");
    check(32'(cnt_out), 32'h000010, "R2 threshold 1 count two");

    rst = 1'b1;
    @(negedge clk);
    check(32'(cnt_out), 0, "R1 counts after mid reset");
    check(32'(err_flags), 0, "R1 flags after mid reset");
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule